// File: doc/BRIEF.md
# DDC Output Word Formatter

This block sits at the end of a digital down-converter channel. It takes one decimated I/Q pair per output sample period. Each pair is a pair of signed 32-bit words qualified by a single valid strobe. The block converts both components to a run-time selected output format. It then sends the pair out on two paths at once: a 16-bit parallel port and a one-bit serial line with a frame strobe.

The formats are:
- 8-bit truncation.
- 16-bit rounding.
- 24-bit rounding.
- Full 32-bit truncation.
- A 12-bit floating-point word: a 4-bit exponent above an 8-bit two's-complement mantissa.

All results are two's complement. A one-cycle ready pulse marks the cycle in which a newly formatted pair first appears on both paths. The parallel port is released to high impedance whenever its output-enable input is low. The serial pins stay undriven until the serial-enable configuration bit is set. A new valid sample restarts both output sequences, even if the previous pair has not finished.

Top module: `ddc_out_fmt`

## Requirements
- R1: `rdy` is high for exactly the one cycle that follows a clock edge at which `in_valid` was sampled high. In that cycle the first parallel beat and the first serial bit of the new pair are presented. `rdy` is low at all other times.
- R2: `fmt_sel` encodings are 0 = 8-bit truncation, 1 = 16-bit rounding, 2 = 24-bit rounding, 3 = 32-bit truncation, 4 = float. The encodings 5, 6 and 7 behave as 32-bit truncation. Truncation keeps the top bits of the 32-bit sample.
- R3: Rounding to 16 or 24 bits adds half an LSB of the target width before dropping the low bits. The result saturates to the most positive code (0x7FFF or 0x7FFFFF) when that addition would overflow.
- R4: The float word has the exponent in bits [11:8] and the mantissa in bits [7:0]. The exponent is the smallest left shift count (at most 15) after which sample bits 31 and 30 differ. The mantissa is bits [31:24] of the shifted sample. A zero sample yields 0xF00.
- R5: Words of 16 bits or fewer are sign-extended from their top bit to 16 bits. They use one parallel beat each, I beat first then Q beat. `par_tag` is {is_Q, 0}.
- R6: Words of 24 or 32 bits are sign-extended to 32 bits and sent as four beats: I high half, I low half, Q high half, Q low half. `par_tag` is {is_Q, low_half}. `par_vld` is high exactly during beats.
- R7: `par_data` is high impedance whenever `par_oe` is low.
- R8: The serial line sends the I word and then the Q word, MSB first, one bit per clock, each word using exactly the width of the selected format. `ser_fs` is high on the first bit of each word. When no frame is active, `ser_fs` is 0 and `ser_dout` is 0.
- R9: `ser_dout` and `ser_fs` are high impedance while `ser_en` is low.
- R10: A valid sample that arrives while a previous pair is still being sent discards the rest of that pair. Both output paths restart with the new pair.
- R11: After reset, `rdy`, `par_vld`, `par_tag` and `ser_fs` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample pair valid strobe |
| in_i | input | 32 | In-phase sample, two's complement |
| in_q | input | 32 | Quadrature sample, two's complement |
| fmt_sel | input | 3 | Output format select |
| par_oe | input | 1 | Parallel port output enable |
| ser_en | input | 1 | Serial pin enable (configuration bit) |
| rdy | output | 1 | New output sample period pulse |
| par_vld | output | 1 | Parallel beat valid |
| par_tag | output | 2 | Beat identity {is_Q, low_half} |
| par_data | output | 16 | Parallel data, tri-stated when disabled |
| ser_dout | output | 1 | Serial data, tri-stated when disabled |
| ser_fs | output | 1 | Serial word frame strobe, tri-stated when disabled |

## Verification
The bound checker watches the ordering rules on every cycle:
- each ready pulse coincides with the first parallel beat (tag 00) and with a serial frame strobe;
- parallel beats run back to back, and the tag changes on every beat;
- the serial strobe never appears outside an active frame.

The numeric content can only be shown by the bench scenarios, which compare every beat and every serial bit against reference formatting functions. This covers saturation during rounding, float normalisation of zero and extreme values, sign extension, and the reserved format codes. The same applies to the high-impedance release of both ports and to restarting in the middle of a frame.

// File: rtl/ddcf_pkg.sv
package ddcf_pkg;
  localparam int SMP_W  = 32;
  localparam int PORT_W = 16;
  localparam int EXP_W  = 4;
  localparam int MAN_W  = 8;
  localparam int FLT_W  = EXP_W + MAN_W;
  localparam int NB_W   = $clog2(2 * SMP_W) + 1;

  typedef enum logic [2:0] {
    FMT_T8  = 3'd0,
    FMT_R16 = 3'd1,
    FMT_R24 = 3'd2,
    FMT_T32 = 3'd3,
    FMT_FLT = 3'd4
  } fmt_e;

  // number of significant bits carried by a format
  function automatic logic [NB_W-1:0] fmt_bits(input logic [2:0] sel);
    case (sel)
      FMT_T8:  fmt_bits = NB_W'(8);
      FMT_R16: fmt_bits = NB_W'(16);
      FMT_R24: fmt_bits = NB_W'(24);
      FMT_FLT: fmt_bits = NB_W'(FLT_W);
      default: fmt_bits = NB_W'(SMP_W);
    endcase
  endfunction
endpackage

// File: rtl/ddcf_fmt.sv
module ddcf_fmt
  import ddcf_pkg::*;
#(
  parameter int W = SMP_W
) (
  input  logic [W-1:0] smp,
  input  logic [2:0]   sel,
  output logic [W-1:0] word
);
  localparam int D16  = W - 16;
  localparam int D24  = W - 24;
  localparam int MAXE = (1 << EXP_W) - 1;

  logic [15:0]      hi16, r16;
  logic [23:0]      hi24, r24;
  logic [7:0]       t8;
  logic [EXP_W-1:0] ex;
  logic [W-1:0]     shf;
  logic [FLT_W-1:0] flt;

  always_comb begin
    t8   = smp[W-1 -: 8];
    hi16 = smp[W-1:D16];
    hi24 = smp[W-1:D24];
    // round half up, clamp at the positive limit
    if (smp[D16-1] && (hi16 == {1'b0, {15{1'b1}}})) r16 = hi16;
    else                                            r16 = hi16 + 16'(smp[D16-1]);
    if (smp[D24-1] && (hi24 == {1'b0, {23{1'b1}}})) r24 = hi24;
    else                                            r24 = hi24 + 24'(smp[D24-1]);
    // normalisation: smallest shift giving differing top two bits
    ex = EXP_W'(MAXE);
    for (int k = MAXE - 1; k >= 0; k--) begin
      if (smp[W-2-k] != smp[W-1]) ex = EXP_W'(k);
    end
    shf = smp << ex;
    flt = {ex, shf[W-1 -: MAN_W]};
  end

  always_comb begin
    case (sel)
      FMT_T8:  word = {{(W-8){t8[7]}}, t8};
      FMT_R16: word = {{(W-16){r16[15]}}, r16};
      FMT_R24: word = {{(W-24){r24[23]}}, r24};
      FMT_FLT: word = {{(W-FLT_W){flt[FLT_W-1]}}, flt};
      default: word = smp;
    endcase
  end
endmodule

// File: rtl/ddcf_par.sv
module ddcf_par
  import ddcf_pkg::*;
#(
  parameter int W  = SMP_W,
  parameter int PW = PORT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  wi,
  input  logic [W-1:0]  wq,
  input  logic          dbl,
  output logic          vld,
  output logic [1:0]    tag,
  output logic [PW-1:0] data
);
  logic [W-1:0] wi_q, wi_d, wq_q, wq_d;
  logic         dbl_q, dbl_d, act_q, act_d;
  logic [1:0]   cnt_q, cnt_d;
  logic         en;

  always_comb begin
    en    = load | act_q;
    wi_d  = wi_q;
    wq_d  = wq_q;
    dbl_d = dbl_q;
    act_d = act_q;
    cnt_d = cnt_q;
    if (load) begin
      wi_d  = wi;
      wq_d  = wq;
      dbl_d = dbl;
      act_d = 1'b1;
      cnt_d = 2'd0;
    end else if (act_q) begin
      if (cnt_q == (dbl_q ? 2'd3 : 2'd1)) act_d = 1'b0;
      else                                 cnt_d = cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wi_q  <= '0;
      wq_q  <= '0;
      dbl_q <= 1'b0;
      act_q <= 1'b0;
      cnt_q <= 2'd0;
    end else if (en) begin
      wi_q  <= wi_d;
      wq_q  <= wq_d;
      dbl_q <= dbl_d;
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    vld = act_q;
    if (dbl_q) begin
      tag = cnt_q;
      case (cnt_q)
        2'd0:    data = wi_q[W-1 -: PW];
        2'd1:    data = wi_q[PW-1:0];
        2'd2:    data = wq_q[W-1 -: PW];
        default: data = wq_q[PW-1:0];
      endcase
    end else begin
      tag  = {cnt_q[0], 1'b0};
      data = cnt_q[0] ? wq_q[PW-1:0] : wi_q[PW-1:0];
    end
    if (!act_q) tag = 2'b00;
  end
endmodule

// File: rtl/ddcf_ser.sv
module ddcf_ser
  import ddcf_pkg::*;
#(
  parameter int W = SMP_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [W-1:0]    wi,
  input  logic [W-1:0]    wq,
  input  logic [NB_W-1:0] nbits,
  output logic            bit_o,
  output logic            fs_o,
  output logic            act_o
);
  localparam int LW = $clog2(W);

  logic [W-1:0]    wi_q, wi_d, wq_q, wq_d;
  logic [NB_W-1:0] nb_q, nb_d, idx_q, idx_d, last, ia, iq;
  logic            act_q, act_d, en, b;

  always_comb begin
    en    = load | act_q;
    last  = (nb_q << 1) - NB_W'(1);
    wi_d  = wi_q;
    wq_d  = wq_q;
    nb_d  = nb_q;
    idx_d = idx_q;
    act_d = act_q;
    if (load) begin
      wi_d  = wi;
      wq_d  = wq;
      nb_d  = nbits;
      idx_d = '0;
      act_d = 1'b1;
    end else if (act_q) begin
      if (idx_q == last) act_d = 1'b0;
      else               idx_d = idx_q + NB_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wi_q  <= '0;
      wq_q  <= '0;
      nb_q  <= '0;
      idx_q <= '0;
      act_q <= 1'b0;
    end else if (en) begin
      wi_q  <= wi_d;
      wq_q  <= wq_d;
      nb_q  <= nb_d;
      idx_q <= idx_d;
      act_q <= act_d;
    end
  end

  always_comb begin
    ia = nb_q - NB_W'(1) - idx_q;
    iq = last - idx_q;
    b  = (idx_q < nb_q) ? wi_q[ia[LW-1:0]] : wq_q[iq[LW-1:0]];
    bit_o = act_q & b;
    fs_o  = act_q & ((idx_q == '0) | (idx_q == nb_q));
    act_o = act_q;
  end
endmodule

// File: rtl/ddc_out_fmt.sv
module ddc_out_fmt
  import ddcf_pkg::*;
#(
  parameter int W  = SMP_W,
  parameter int PW = PORT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_i,
  input  logic [W-1:0]  in_q,
  input  logic [2:0]    fmt_sel,
  input  logic          par_oe,
  input  logic          ser_en,
  output logic          rdy,
  output logic          par_vld,
  output logic [1:0]    par_tag,
  output logic [PW-1:0] par_data,
  output logic          ser_dout,
  output logic          ser_fs
);
  logic [1:0]      rs_q;
  logic            rst_s;
  logic [W-1:0]    smp [2];
  logic [W-1:0]    word [2];
  logic [NB_W-1:0] nbits;
  logic            dbl;
  logic            rdy_q;
  logic [PW-1:0]   pdat;
  logic            sbit, ser_fs_raw, ser_act;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  assign smp[0] = in_i;
  assign smp[1] = in_q;

  for (genvar g = 0; g < 2; g++) begin : g_fmt
    ddcf_fmt #(.W(W)) u_fmt (
      .smp  (smp[g]),
      .sel  (fmt_sel),
      .word (word[g])
    );
  end

  assign nbits = fmt_bits(fmt_sel);
  assign dbl   = nbits > NB_W'(PW);

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) rdy_q <= 1'b0;
    else        rdy_q <= in_valid;
  end
  assign rdy = rdy_q;

  ddcf_par #(.W(W), .PW(PW)) u_par (
    .clk  (clk),
    .rst_n(rst_s),
    .load (in_valid),
    .wi   (word[0]),
    .wq   (word[1]),
    .dbl  (dbl),
    .vld  (par_vld),
    .tag  (par_tag),
    .data (pdat)
  );

  ddcf_ser #(.W(W)) u_ser (
    .clk  (clk),
    .rst_n(rst_s),
    .load (in_valid),
    .wi   (word[0]),
    .wq   (word[1]),
    .nbits(nbits),
    .bit_o(sbit),
    .fs_o (ser_fs_raw),
    .act_o(ser_act)
  );

  assign par_data = par_oe ? pdat : 'z;
  assign ser_dout = ser_en ? sbit : 1'bz;
  assign ser_fs   = ser_en ? ser_fs_raw : 1'bz;
endmodule

// File: rtl/ddc_out_fmt_chk.sv
module ddc_out_fmt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rdy,
  input logic       pv,
  input logic [1:0] ptag,
  input logic       sfs,
  input logic       sact
);
  // R1
  rdy_par_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> (pv && ptag == 2'b00));

  // R8
  rdy_ser_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> (sfs && sact));

  // R6
  beats_contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && !rdy) |-> $past(pv));

  // R5
  tag_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $past(pv) && !rdy) |-> (ptag != $past(ptag)));

  // R8
  fs_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sfs |-> sact);
endmodule

bind ddc_out_fmt ddc_out_fmt_chk u_chk (
  .clk (clk),
  .rst_n(rst_n),
  .rdy (rdy),
  .pv  (par_vld),
  .ptag(par_tag),
  .sfs (ser_fs_raw),
  .sact(ser_act)
);

// File: tb/sim_ddc_out_fmt.sv
module sim_ddc_out_fmt;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_i, in_q;
  logic [2:0]  fmt_sel;
  logic        par_oe, ser_en;
  wire         rdy, par_vld;
  wire  [1:0]  par_tag;
  wire  [15:0] par_data;
  wire         ser_dout, ser_fs;
  int          nvec = 0;
  int          nerr = 0;
  string       scen = "";

  always #5 clk = ~clk;

  ddc_out_fmt u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .fmt_sel(fmt_sel), .par_oe(par_oe), .ser_en(ser_en), .rdy(rdy),
    .par_vld(par_vld), .par_tag(par_tag), .par_data(par_data),
    .ser_dout(ser_dout), .ser_fs(ser_fs)
  );

  function automatic int fbits(int f);
    case (f)
      0: return 8;
      1: return 16;
      2: return 24;
      4: return 12;
      default: return 32;
    endcase
  endfunction

  function automatic string freq(int f);
    case (f)
      1, 2: return "R3";
      4: return "R4";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [31:0] ref_word(int f, logic [31:0] x);
    longint sx, v;
    logic [31:0] s;
    logic [11:0] fw;
    int e;
    sx = longint'($signed(x));
    case (f)
      0: v = sx >>> 24;
      1: begin v = (sx + 32768) >>> 16; if (v > 32767) v = 32767; end
      2: begin v = (sx + 128) >>> 8; if (v > 8388607) v = 8388607; end
      4: begin
        s = x; e = 0;
        while (e < 15 && s[31] == s[30]) begin s = s << 1; e++; end
        fw = {4'(e), s[31:24]};
        return {{20{fw[11]}}, fw};
      end
      default: v = sx;
    endcase
    return v[31:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", req, scen, act, exp);
    end
  endtask

  task automatic run(int f, logic [31:0] xi, logic [31:0] xq, int lim);
    int w, nb, tot;
    logic [31:0] ei, eq;
    logic [15:0] pd;
    logic [1:0]  tg;
    logic        eb;
    bit          hot;
    w  = fbits(f);
    ei = ref_word(f, xi);
    eq = ref_word(f, xq);
    nb = (w > 16) ? 4 : 2;
    tot = (2 * w > nb) ? 2 * w : nb;
    if (lim < tot) tot = lim;
    @(negedge clk);
    in_valid = 1'b1; in_i = xi; in_q = xq; fmt_sel = 3'(f);
    @(negedge clk);
    in_valid = 1'b0;
    for (int c = 0; c < tot; c++) begin
      if (c > 0) @(negedge clk);
      chk(rdy === (c == 0), "R1", 32'(rdy), 32'(c == 0));
      if (par_oe) begin
        if (c < nb) begin
          if (w > 16) begin
            case (c)
              0: pd = ei[31:16];
              1: pd = ei[15:0];
              2: pd = eq[31:16];
              default: pd = eq[15:0];
            endcase
            tg = 2'(c);
            chk(par_vld === 1'b1 && par_tag === tg, "R6", {30'd0, par_tag}, {30'd0, tg});
          end else begin
            pd = (c == 0) ? ei[15:0] : eq[15:0];
            tg = {c[0], 1'b0};
            chk(par_vld === 1'b1 && par_tag === tg, "R5", {30'd0, par_tag}, {30'd0, tg});
          end
          chk(par_data === pd, freq(f), {16'd0, par_data}, {16'd0, pd});
        end else begin
          chk(par_vld === 1'b0, "R6", 32'(par_vld), 32'd0);
        end
      end else begin
        hot = 1'b0;
        for (int b = 0; b < 16; b++) if (par_data[b] === 1'b1) hot = 1'b1;
        chk(!hot, "R7", {16'd0, par_data}, 32'hzzzz);
      end
      if (ser_en) begin
        if (c < 2 * w) eb = (c < w) ? ei[w-1-c] : eq[2*w-1-c];
        else           eb = 1'b0;
        chk(ser_dout === eb, "R8", 32'(ser_dout), 32'(eb));
        chk(ser_fs === (c == 0 || c == w), "R8", 32'(ser_fs), 32'(c == 0 || c == w));
      end else begin
        chk(ser_dout !== 1'b1 && ser_fs !== 1'b1, "R9", {30'd0, ser_dout, ser_fs}, 32'hz);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog %s: actual timeout expected completion", scen);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd4021));
    rst_n = 1'b0; in_valid = 1'b0; in_i = '0; in_q = '0; fmt_sel = 3'd0;
    par_oe = 1'b1; ser_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    scen = "reset";
    chk(rdy === 1'b0 && par_vld === 1'b0 && par_tag === 2'b00 && ser_fs === 1'b0,
        "R11", {28'd0, rdy, par_vld, par_tag}, 32'd0);

    scen = "directed";
    run(0, 32'h87654321, 32'h12345678, 99);
    run(3, 32'hA5A5_0F0F, 32'h0000_0001, 99);
    run(6, 32'h8000_0000, 32'h7FFF_FFFF, 99);
    run(1, 32'h7FFF_8000, 32'hFFFF_8000, 99);   // saturate, negative round to 0
    run(1, 32'h1234_7FFF, 32'h8000_0000, 99);
    run(2, 32'h7FFF_FF80, 32'hFFFF_FF7F, 99);
    run(4, 32'h0000_0000, 32'hFFFF_FFFF, 99);   // zero gives F00
    run(4, 32'h8000_0000, 32'h4000_0000, 99);
    run(4, 32'h0001_2345, 32'hFFFE_0000, 99);

    scen = "R10 restart";
    run(3, 32'hDEAD_BEEF, 32'h0BAD_F00D, 5);
    run(0, 32'h7F00_0000, 32'h8100_0000, 99);
    run(2, 32'hCAFE_1234, 32'h5555_AAAA, 3);
    run(4, 32'h0070_0000, 32'hFF80_0000, 99);

    scen = "R7 R9 disabled";
    par_oe = 1'b0; ser_en = 1'b0;
    run(3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 99);
    par_oe = 1'b1;
    run(0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 99);
    par_oe = 1'b0; ser_en = 1'b1;
    run(1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 99);
    par_oe = 1'b1;

    scen = "random";
    for (int n = 0; n < 40; n++) begin
      run(int'($urandom % 8), $urandom, $urandom, 99);
    end

    @(negedge clk);
    scen = "idle";
    chk(rdy === 1'b0 && par_vld === 1'b0 && ser_fs === 1'b0 && ser_dout === 1'b0,
        "R8", {28'd0, rdy, par_vld, ser_fs, ser_dout}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule